// File: doc/BRIEF.md
# Three-Lane Pixel Vector Multiply-Accumulate

This block is a pipelined arithmetic engine for pixel streams. Every accepted input beat carries three unsigned 8-bit components. All three lanes see the same triple. Each lane weights the components with its own three signed fixed-point coefficients and sums the products at full precision.

A global mode bit picks what happens to that sum. In direct mode each lane adds its own signed offset; this suits colour-space conversion, where the offset re-centres chroma. In accumulate mode the sum is added into a per-lane running total, and a result is released only when a beat marked as the last pass arrives; this lets taps be spread across several passes to build longer filters. In both modes the value is rounded, arithmetically shifted right by a programmable amount (which places the binary point of the coefficients) and clamped to 0..255.

Configuration is written through a simple write port. Input and output use valid/ready handshakes, and a stall at the output freezes the whole pipeline in place.

Top module: `pix_vmac3`

## Requirements
- R1: While reset is low and just after it is released, out_valid is 0 and in_ready is 1. All coefficients, offsets, the shift and the mode reset to zero, so a beat sent right after reset gives 0 on all three lanes.
- R2: A write (cfg_we high at a clock edge) decodes cfg_addr as follows. Addresses 0..8 set coefficient lane=addr/3, tap=addr%3 from cfg_wdata[11:0], signed. Addresses 9..11 set the offset of lane addr-9 from cfg_wdata[15:0], signed. Address 12 sets the shift from cfg_wdata[3:0] and accumulate mode from cfg_wdata[4]. Writes to addresses 13..15 change nothing.
- R3: Input component t is in_pix[8t+7:8t], unsigned. Lane l computes the sum over t of component t × coefficient (l,t), and its result appears on out_pix[8l+7:8l].
- R4: In direct mode (mode bit 0), the lane's offset is added to the sum before rounding and shifting.
- R5: With shift s > 0, the value v becomes (v + 2^(s-1)) >>> s, an arithmetic shift. With s = 0, v is passed unchanged.
- R6: After shifting, values below 0 give 0 and values above 255 give 255.
- R7: If a beat is accepted at clock edge k and out_ready stays high, its result is on out_pix with out_valid high after edge k+2, and not before.
- R8: While out_ready stays high, in_ready stays high, and one beat per clock is accepted and produced.
- R9: While out_valid is high and out_ready is low, out_pix and out_valid hold and in_ready is low. No result is lost or repeated.
- R10: In accumulate mode (mode bit 1), each beat's sum is added to the lane accumulator and the offset is not used. out_valid rises only for a beat with in_last high; its result is the total including that beat. The accumulator then restarts at zero.
- R11: acc_clr high at a clock edge zeroes all three accumulators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address |
| cfg_wdata | input | 16 | Configuration write data |
| acc_clr | input | 1 | Zero all accumulators |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_pix | input | 24 | Three 8-bit input components |
| in_last | input | 1 | Beat is the final pass (accumulate mode) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_pix | output | 24 | Three 8-bit lane results |

## Verification
The bench sweeps one input component through all 256 values under several coefficient sets, and sends both very large positive and very large negative sums. A clamp that wraps instead of saturating shows up as small values where 255 or 0 is expected. Odd values at shifts of 1 and 2 catch rounding that is dropped or applied to the wrong bit.

Random back-pressure checks that a stalled result neither changes nor goes missing, and that nothing is repeated. Accumulate runs with pass counts from one to four, plus runs cut by a clear strobe, expose an accumulator that does not restart after the last pass, leaks offsets into the total, or flags partial results as valid.

// File: rtl/pix_vmac3.sv
module pix_vmac3 #(
  parameter int PIX_W   = 8,
  parameter int COEF_W  = 12,
  parameter int OFF_W   = 16,
  parameter int SHIFT_W = 4,
  parameter int LANES   = 3,
  parameter int TAPS    = 3,
  parameter int ACC_W   = 32,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [DATA_W-1:0]       cfg_wdata,
  input  logic                    acc_clr,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [TAPS*PIX_W-1:0]   in_pix,
  input  logic                    in_last,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*PIX_W-1:0]  out_pix
);

  localparam int PROD_W    = PIX_W + 1 + COEF_W;
  localparam int SUM_W     = PROD_W + $clog2(TAPS);
  localparam int NCOEF     = LANES * TAPS;
  localparam int OFF_BASE  = NCOEF;
  localparam int CTRL_ADDR = NCOEF + LANES;
  localparam int MODE_BIT  = SHIFT_W;
  localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);

  logic signed [COEF_W-1:0] coef_q [NCOEF];
  logic signed [OFF_W-1:0]  offs_q [LANES];
  logic [SHIFT_W-1:0]       shift_q;
  logic                     acc_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCOEF; i++) coef_q[i] <= '0;
      for (int i = 0; i < LANES; i++) offs_q[i] <= '0;
      shift_q  <= '0;
      acc_mode <= 1'b0;
    end else if (cfg_we) begin
      for (int i = 0; i < NCOEF; i++)
        if (cfg_addr == ADDR_W'(i)) coef_q[i] <= cfg_wdata[COEF_W-1:0];
      for (int i = 0; i < LANES; i++)
        if (cfg_addr == ADDR_W'(OFF_BASE + i)) offs_q[i] <= cfg_wdata[OFF_W-1:0];
      if (cfg_addr == ADDR_W'(CTRL_ADDR)) begin
        shift_q  <= cfg_wdata[SHIFT_W-1:0];
        acc_mode <= cfg_wdata[MODE_BIT];
      end
    end
  end

  logic adv, v1, l1, v2, l2, emit;
  assign adv      = out_ready || !out_valid;
  assign in_ready = adv;
  assign emit     = v2 && (!acc_mode || l2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; l1 <= 1'b0; v2 <= 1'b0; l2 <= 1'b0; out_valid <= 1'b0;
    end else if (adv) begin
      v1        <= in_valid;
      l1        <= in_last;
      v2        <= v1;
      l2        <= l1;
      out_valid <= emit;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [PROD_W-1:0] op_pix  [TAPS];
    logic signed [PROD_W-1:0] op_coef [TAPS];
    logic signed [PROD_W-1:0] prod_q  [TAPS];
    logic signed [SUM_W-1:0]  sum_c, sum_q;
    logic signed [ACC_W-1:0]  acc_q, sum_x, off_x, pre, rnd, scl;
    logic [PIX_W-1:0]         res_c, res_q;

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign op_pix[t]  = PROD_W'($signed({1'b0, in_pix[t*PIX_W +: PIX_W]}));
      assign op_coef[t] = PROD_W'(coef_q[l*TAPS + t]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   prod_q[t] <= '0;
        else if (adv) prod_q[t] <= op_pix[t] * op_coef[t];
      end
    end

    always_comb begin
      sum_c = '0;
      for (int t = 0; t < TAPS; t++) sum_c = sum_c + SUM_W'(prod_q[t]);
    end

    assign sum_x = ACC_W'(sum_q);
    assign off_x = ACC_W'(offs_q[l]);
    assign pre   = acc_mode ? acc_q + sum_x : sum_x + off_x;
    assign rnd   = pre + ((ACC_W'(1) << shift_q) >> 1);
    assign scl   = rnd >>> shift_q;
    assign res_c = (scl < 0) ? '0 : (scl > PIX_MAX) ? '1 : scl[PIX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q <= '0;
        acc_q <= '0;
        res_q <= '0;
      end else begin
        if (adv) sum_q <= sum_c;
        if (acc_clr)                       acc_q <= '0;
        else if (adv && v2 && acc_mode)    acc_q <= l2 ? '0 : pre;
        if (adv && emit) res_q <= res_c;
      end
    end

    assign out_pix[l*PIX_W +: PIX_W] = res_q;
  end

endmodule

// File: rtl/pix_vmac3_chk.sv
module pix_vmac3_chk #(
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_pix,
  input logic             acc_mode,
  input logic             v2,
  input logic             l2
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |-> !out_valid);

  // R9
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  // R8
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready, 3) && $past(out_ready, 2) && $past(out_ready, 1)
     && !$past(acc_mode, 1)) |-> out_valid);

  // R10
  partial_pass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_mode && v2 && !l2 && out_ready) |=> !out_valid);

endmodule

bind pix_vmac3 pix_vmac3_chk #(.OUT_W(LANES*PIX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
  .acc_mode(acc_mode), .v2(v2), .l2(l2)
);

// File: tb/test_pix_vmac3.sv
`timescale 1ns/1ps
module test_pix_vmac3;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0, cfg_we = 1'b0, acc_clr = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        in_valid = 1'b0, in_last = 1'b0, in_ready, out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] in_pix = '0, out_pix;

  pix_vmac3 i_pix_vmac3 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acc_clr(acc_clr), .in_valid(in_valid),
    .in_ready(in_ready), .in_pix(in_pix), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  int nchk = 0, nfail = 0, wr = 0, rd = 0, waits = 0;
  int cf [9];
  int of [3];
  int accm [3];
  int sh = 0;
  bit am = 0, bp_en = 0, done = 0, hold_pend = 0;
  logic [23:0] expm [0:8191];
  logic [23:0] held;
  logic [31:0] rs = 32'h1234_5678, ps = 32'hCAFE_0001;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (bp_en) begin
      rs = rs * 32'd1664525 + 32'd1013904223;
      out_ready = rs[17];
    end else out_ready = 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (hold_pend) chk(out_valid && out_pix == held, "R9", {7'd0, out_valid, out_pix}, {8'd1, held});
      hold_pend = out_valid && !out_ready;
      held = out_pix;
      if (out_valid && out_ready) begin
        if (rd >= wr) chk(1'b0, cur_req, {8'd0, out_pix}, 32'hFFFF_FFFF);
        else begin
          chk(out_pix == expm[rd], cur_req, {8'd0, out_pix}, {8'd0, expm[rd]});
          rd++;
        end
      end
    end
  end

  function automatic int sc(input int v);
    int r = v;
    if (sh > 0) r = r + (1 << (sh - 1));
    r = r >>> sh;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  function automatic int dotp(input int l, input logic [23:0] px);
    int s = 0;
    for (int t = 0; t < 3; t++) s = s + cf[l*3 + t] * int'(px[t*8 +: 8]);
    return s;
  endfunction

  function automatic logic [7:0] rnd8();
    ps = ps * 32'd1103515245 + 32'd12345;
    return ps[23:16];
  endfunction

  task automatic cfgw(input int a, input int d);
    cfg_we = 1'b1; cfg_addr = a[3:0]; cfg_wdata = d[15:0];
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (a < 9) cf[a] = d;
    else if (a < 12) of[a-9] = d;
    else if (a == 12) begin sh = d & 15; am = d[4]; end
  endtask

  task automatic lanes(input int c0, input int c1, input int c2, input int c3, input int c4,
                       input int c5, input int c6, input int c7, input int c8);
    cfgw(0, c0); cfgw(1, c1); cfgw(2, c2);
    cfgw(3, c3); cfgw(4, c4); cfgw(5, c5);
    cfgw(6, c6); cfgw(7, c7); cfgw(8, c8);
  endtask

  task automatic push(input logic [23:0] px, input bit last);
    logic [23:0] e = '0;
    for (int l = 0; l < 3; l++) begin
      if (!am) e[l*8 +: 8] = 8'(sc(dotp(l, px) + of[l]));
      else accm[l] = accm[l] + dotp(l, px);
    end
    if (!am) begin expm[wr] = e; wr++; end
    else if (last) begin
      for (int l = 0; l < 3; l++) begin e[l*8 +: 8] = 8'(sc(accm[l])); accm[l] = 0; end
      expm[wr] = e; wr++;
    end
    in_valid = 1'b1; in_pix = px; in_last = last;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      waits++;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic drain();
    while (rd != wr) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic sweep(input int n);
    for (int i = 0; i < n; i++) push({rnd8(), rnd8(), 8'(i)}, 1'b0);
    drain();
  endtask

  task automatic pulse_clr();
    acc_clr = 1'b1;
    @(posedge clk); #1;
    acc_clr = 1'b0;
    for (int l = 0; l < 3; l++) accm[l] = 0;
  endtask

  initial begin
    #750000;
    if (!done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", rd, wr);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 9; i++) cf[i] = 0;
    for (int i = 0; i < 3; i++) begin of[i] = 0; accm[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: idle during reset
    chk(!out_valid && in_ready, "R1", {30'd0, out_valid, in_ready}, 32'd1);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && in_ready, "R1", {30'd0, out_valid, in_ready}, 32'd1);
    @(posedge clk); #1;
    // R1: zeroed configuration gives zero results
    cur_req = "R1";
    push({8'd200, 8'd100, 8'd50}, 1'b0);
    drain();

    // R7: latency of three register stages
    cur_req = "R7";
    lanes(1, 0, 0, 0, 1, 0, 0, 0, 1);
    cfgw(12, 0);
    push({8'd33, 8'd22, 8'd11}, 1'b0);
    @(negedge clk); chk(!out_valid, "R7", {31'd0, out_valid}, 32'd0);
    @(negedge clk); chk(!out_valid, "R7", {31'd0, out_valid}, 32'd0);
    @(negedge clk); chk(out_valid, "R7", {31'd0, out_valid}, 32'd1);
    @(posedge clk); #1;
    drain();

    // R3: dot products per lane, no offsets
    cur_req = "R3";
    lanes(38, 75, 15, -22, -42, 64, 64, -54, -10);
    cfgw(12, 7);
    sweep(256);

    // R4: offsets in direct mode
    cur_req = "R4";
    cfgw(9, 16384); cfgw(10, 16384); cfgw(11, -3000);
    sweep(256);

    // R5: rounding at shifts 2 and 1
    cur_req = "R5";
    cfgw(9, 0); cfgw(10, 0); cfgw(11, 0);
    lanes(1, 0, 0, 0, 3, 0, 1, 1, 1);
    cfgw(12, 2);
    sweep(256);
    cfgw(12, 1);
    sweep(128);

    // R6: saturation both ways
    cur_req = "R6";
    lanes(2047, 2047, 2047, -2048, -2048, -2048, 2047, -2048, 0);
    cfgw(12, 0);
    sweep(256);

    // R2: unused addresses change nothing
    cur_req = "R2";
    lanes(5, -7, 9, 100, 0, -1, 0, 50, 3);
    cfgw(12, 3);
    cfgw(13, 16'hFFFF); cfgw(14, 16'hFFFF); cfgw(15, 16'hFFFF);
    sweep(64);

    // R8: full rate with no back-pressure
    cur_req = "R8";
    waits = 0;
    sweep(128);
    chk(waits == 0, "R8", waits, 0);

    // R9: random back-pressure
    cur_req = "R9";
    bp_en = 1; waits = 0;
    for (int i = 0; i < 300; i++) push({rnd8(), rnd8(), rnd8()}, 1'b0);
    while (rd != wr) @(posedge clk);
    #1;
    bp_en = 0;
    drain();
    chk(waits > 0, "R9", waits, 1);

    // R10: multi-pass accumulation, offsets ignored
    cur_req = "R10";
    cfgw(9, 5000); cfgw(10, -5000); cfgw(11, 777);
    lanes(10, -3, 7, 2, 2, 2, -9, 15, 4);
    cfgw(12, 16 | 2);
    for (int g = 0; g < 40; g++)
      for (int k = 0; k <= g % 4; k++) push({rnd8(), rnd8(), rnd8()}, k == g % 4);
    drain();
    for (int k = 0; k < 3; k++) push({rnd8(), rnd8(), rnd8()}, 1'b0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); chk(!out_valid, "R10", {31'd0, out_valid}, 32'd0);
    end
    @(posedge clk); #1;
    push({rnd8(), rnd8(), rnd8()}, 1'b1);
    drain();
    bp_en = 1;
    for (int g = 0; g < 30; g++)
      for (int k = 0; k < 3; k++) push({rnd8(), rnd8(), rnd8()}, k == 2);
    while (rd != wr) @(posedge clk);
    #1;
    bp_en = 0;
    drain();

    // R11: clear strobe drops partial totals
    cur_req = "R11";
    for (int g = 0; g < 8; g++) begin
      push({rnd8(), rnd8(), rnd8()}, 1'b0);
      push({rnd8(), rnd8(), rnd8()}, 1'b0);
      drain();
      pulse_clr();
      push({rnd8(), rnd8(), rnd8()}, 1'b1);
      drain();
    end
    chk(rd == wr, "R11", rd, wr);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule